// File: doc/BRIEF.md
# Multi-Variant Left Shifter

This block shifts a word-width operand left by a count and returns the result one clock after the input is presented. A two-bit selector picks one of four variants. Plain shift: overshifted bits are dropped. Trapping shift: any loss of value is reported as a poisoned output. Signed saturating shift: the result clamps to the most positive or most negative value. Widening shift: the result is twice the operand width.

Each variant has its own defined result when the count reaches or exceeds the operand width. The count is used exactly as given and is never reduced modulo the width, so a shift by the width does not behave like a shift by zero. A poisoned output is marked by the not-a-result flag, and its result field reads zero. An operand that arrives already poisoned stays poisoned through every variant.

The block sits in an execution pipeline. A producer asserts the input valid with the operand, count and selector. One cycle later the output valid rises with the registered result. The operand width and the count width are parameters.

Top module: `shl_unit`

## Requirements
- R1: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low in the cycle after a cycle with `in_valid` low. While reset is held, `out_valid`, `out_nar` and `out_result` are all zero.
- R2: The selector encodes the variants as 2'b00 plain, 2'b01 trapping, 2'b10 saturating and 2'b11 widening. For plain with count < W, the result is the low W bits of operand << count. For plain with count >= W, the result is zero and `out_nar` is 0.
- R3: For trapping with count < W, when the sign-extended operand shifted left fits in W signed bits, the result is the low W bits of the shifted value and `out_nar` is 0.
- R4: For trapping with count < W, when any bit shifted out differs from the sign bit of the result, `out_nar` is 1 and the result is zero.
- R5: For trapping with count >= W, `out_nar` is 1 and the result is zero, even when the operand is zero.
- R6: For saturating, the operand is signed. When the shifted value fits in W signed bits, the result is the low W bits of the shifted value.
- R7: For saturating, when the shifted value does not fit, or when count >= W with a nonzero operand, the result is 0x7F..F for a non-negative operand and 0x80..0 for a negative one. A zero operand gives zero for every count. `out_nar` is always 0 for this variant.
- R8: For widening with count < 2W, the result is the 2W-bit zero-extended operand shifted left by the count, and `out_nar` is 0.
- R9: For widening with count >= 2W, the result is zero and `out_nar` is 0.
- R10: When `in_nar` is 1, `out_nar` is 1 and the result is zero, whatever the variant and count.
- R11: The count is never taken modulo W. For the plain variant, a count of W + k gives zero rather than the result for k.
- R12: For the three non-widening variants, the upper W bits of `out_result` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input qualifier |
| in_op | input | 2 | Variant selector (00 plain, 01 trapping, 10 saturating, 11 widening) |
| in_opnd | input | W | Operand |
| in_nar | input | 1 | Operand is already poisoned |
| in_count | input | CNT_W | Unsigned shift count |
| out_valid | output | 1 | Result qualifier, one cycle after `in_valid` |
| out_result | output | 2W | Shifted result; only the low W bits are used except in widening |
| out_nar | output | 1 | Result is not a value |

## Verification
The operands are chosen to tell the overflow rules apart. They include small positive values that shift cleanly, values that lose a set bit, negative values whose shifted-out ones match the final sign, and negative values whose sign flips. Counts are swept from zero across W and 2W up to the top of the count range, so each variant's boundary at W or 2W is crossed in both directions. Zero operands under large counts separate the trapping variant, which must poison, from the saturating variant, which must return zero. Poisoned inputs are applied under every selector to show that the flag overrides each variant.

// File: rtl/shl_pkg.sv
package shl_pkg;

    typedef enum logic [1:0] {
        OP_PLAIN = 2'b00,
        OP_TRAP  = 2'b01,
        OP_SAT   = 2'b10,
        OP_WIDE  = 2'b11
    } shl_op_e;

endpackage

// File: rtl/shl_barrel.sv
module shl_barrel #(
    parameter int DW = 64,
    parameter int SW = 6
) (
    input  logic [DW-1:0] data_i,
    input  logic [SW-1:0] amt_i,
    output logic [DW-1:0] data_o
);
    logic [SW:0][DW-1:0] stage;

    assign stage[0] = data_i;

    for (genvar k = 0; k < SW; k++) begin : g_stage
        assign stage[k+1] = amt_i[k] ? (stage[k] << (1 << k)) : stage[k];
    end

    assign data_o = stage[SW];
endmodule

// File: rtl/shl_unit.sv
module shl_unit #(
    parameter int W     = 32,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       in_op,
    input  logic [W-1:0]     in_opnd,
    input  logic             in_nar,
    input  logic [CNT_W-1:0] in_count,
    output logic             out_valid,
    output logic [2*W-1:0]   out_result,
    output logic             out_nar
);
    import shl_pkg::*;

    localparam int DW = 2 * W;
    localparam int SW = $clog2(DW);
    localparam logic [CNT_W-1:0] LIM_NARROW = CNT_W'(W);
    localparam logic [CNT_W-1:0] LIM_WIDE   = CNT_W'(DW);
    localparam logic [W-1:0] SAT_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SAT_MIN = {1'b1, {(W-1){1'b0}}};

    typedef struct packed {
        logic          valid;
        logic          nar;
        logic [DW-1:0] res;
    } out_st_t;

    out_st_t st_d, st_q;

    logic [DW-1:0] sext_in, zext_in, sext_sh, zext_sh;
    logic [SW-1:0] amt;

    assign amt     = in_count[SW-1:0];
    assign sext_in = {{W{in_opnd[W-1]}}, in_opnd};
    assign zext_in = {{W{1'b0}}, in_opnd};

    shl_barrel #(.DW(DW), .SW(SW)) u_sext_shift (
        .data_i (sext_in),
        .amt_i  (amt),
        .data_o (sext_sh)
    );

    shl_barrel #(.DW(DW), .SW(SW)) u_zext_shift (
        .data_i (zext_in),
        .amt_i  (amt),
        .data_o (zext_sh)
    );

    logic          over_narrow, over_wide, lost_bits, opnd_zero;
    logic [W:0]    high_part;
    logic [W-1:0]  narrow_val;
    shl_op_e       op;

    always_comb begin
        op          = shl_op_e'(in_op);
        over_narrow = (in_count >= LIM_NARROW);
        over_wide   = (in_count >= LIM_WIDE);
        narrow_val  = sext_sh[W-1:0];
        high_part   = sext_sh[DW-1:W-1];
        lost_bits   = !((&high_part) || !(|high_part));
        opnd_zero   = (in_opnd == '0);

        st_d = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.nar = 1'b0;
            st_d.res = '0;
            unique case (op)
                OP_PLAIN: begin
                    if (!over_narrow) st_d.res = {{W{1'b0}}, narrow_val};
                end
                OP_TRAP: begin
                    if (over_narrow || lost_bits) st_d.nar = 1'b1;
                    else                          st_d.res = {{W{1'b0}}, narrow_val};
                end
                OP_SAT: begin
                    if (opnd_zero)
                        st_d.res = '0;
                    else if (over_narrow || lost_bits)
                        st_d.res = {{W{1'b0}}, (in_opnd[W-1] ? SAT_MIN : SAT_MAX)};
                    else
                        st_d.res = {{W{1'b0}}, narrow_val};
                end
                OP_WIDE: begin
                    if (!over_wide) st_d.res = zext_sh;
                end
                default: st_d.res = '0;
            endcase
            if (in_nar) begin
                st_d.nar = 1'b1;
                st_d.res = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid  = st_q.valid;
    assign out_nar    = st_q.nar;
    assign out_result = st_q.res;
endmodule

// File: rtl/shl_unit_chk.sv
module shl_unit_chk #(
    parameter int W     = 32,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [1:0]       in_op,
    input logic [W-1:0]     in_opnd,
    input logic             in_nar,
    input logic [CNT_W-1:0] in_count,
    input logic             out_valid,
    input logic [2*W-1:0]   out_result,
    input logic             out_nar
);
    localparam logic [CNT_W-1:0] LIM_N = CNT_W'(W);
    localparam logic [CNT_W-1:0] LIM_W = CNT_W'(2 * W);

    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_plain_overshift_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 2'b00 && !in_nar && in_count >= LIM_N)
        |=> (out_result == '0 && !out_nar));

    assert_trap_overshift_poison_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 2'b01 && in_count >= LIM_N) |=> out_nar);

    assert_no_poison_sat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 2'b10 && !in_nar) |=> !out_nar);

    assert_wide_overshift_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 2'b11 && !in_nar && in_count >= LIM_W)
        |=> (out_result == '0 && !out_nar));

    assert_poison_passes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_nar) |=> (out_nar && out_result == '0));

    assert_upper_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op != 2'b11) |=> (out_result[2*W-1:W] == '0));
endmodule

bind shl_unit shl_unit_chk #(.W(W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_op      (in_op),
    .in_opnd    (in_opnd),
    .in_nar     (in_nar),
    .in_count   (in_count),
    .out_valid  (out_valid),
    .out_result (out_result),
    .out_nar    (out_nar)
);

// File: tb/sim_shl_unit.sv
`timescale 1ns/1ps
module sim_shl_unit;
    localparam int W     = 32;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [1:0]       in_op = 2'b00;
    logic [W-1:0]     in_opnd = '0;
    logic             in_nar = 1'b0;
    logic [CNT_W-1:0] in_count = '0;
    logic             out_valid;
    logic [2*W-1:0]   out_result;
    logic             out_nar;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    shl_unit #(.W(W), .CNT_W(CNT_W)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_op      (in_op),
        .in_opnd    (in_opnd),
        .in_nar     (in_nar),
        .in_count   (in_count),
        .out_valid  (out_valid),
        .out_result (out_result),
        .out_nar    (out_nar)
    );

    task automatic check(input bit ok, input string tag, input logic [64:0] act,
                         input logic [64:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference built from the requirement text, 32-bit operand.
    function automatic logic [64:0] model(input logic [1:0] op, input logic [31:0] a,
                                          input bit nar, input int c);
        longint prod;
        logic [63:0] w;
        if (nar) return {1'b1, 64'd0};
        case (op)
            2'b00: return (c >= 32) ? 65'd0 : {33'd0, a << c};
            2'b01: begin
                if (c >= 32) return {1'b1, 64'd0};
                prod = longint'($signed(a)) <<< c;
                if (prod > 64'sd2147483647 || prod < -64'sd2147483648) return {1'b1, 64'd0};
                return {33'd0, prod[31:0]};
            end
            2'b10: begin
                if (a == 0) return 65'd0;
                if (c >= 32) return {33'd0, a[31] ? 32'h80000000 : 32'h7FFFFFFF};
                prod = longint'($signed(a)) <<< c;
                if (prod > 64'sd2147483647)  return {33'd0, 32'h7FFFFFFF};
                if (prod < -64'sd2147483648) return {33'd0, 32'h80000000};
                return {33'd0, prod[31:0]};
            end
            default: begin
                if (c >= 64) return 65'd0;
                w = {32'd0, a};
                return {1'b0, w << c};
            end
        endcase
    endfunction

    // Presents one operation and samples the registered output a cycle later.
    task automatic apply(input logic [1:0] op, input logic [31:0] a, input bit nar,
                         input int c, output logic [64:0] got);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_opnd = a; in_nar = nar; in_count = CNT_W'(c);
        @(negedge clk);
        in_valid = 1'b0;
        got = {out_nar, out_result};
        check(out_valid == 1'b1, "R1 valid after input", {64'd0, out_valid}, 65'd1);
    endtask

    task automatic run_model(input logic [1:0] op, input logic [31:0] a, input bit nar,
                             input int c, input string tag);
        logic [64:0] got, exp;
        apply(op, a, nar, c, got);
        exp = model(op, a, nar, c);
        check(got == exp, tag, got, exp);
    endtask

    task automatic run_fixed(input logic [1:0] op, input logic [31:0] a, input bit nar,
                             input int c, input logic [64:0] exp, input string tag);
        logic [64:0] got;
        apply(op, a, nar, c, got);
        check(got == exp, tag, got, exp);
    endtask

    task automatic t_reset;
        check(out_valid == 0 && out_nar == 0 && out_result == 0, "R1 reset state",
              {out_nar, out_result}, 65'd0);
    endtask

    task automatic t_idle;
        @(negedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R1 idle drops valid", {64'd0, out_valid}, 65'd0);
    endtask

    task automatic t_plain;
        run_fixed(2'b00, 32'h0000_0003, 0, 4,  65'h30, "R2 plain in range");
        run_fixed(2'b00, 32'hF000_0001, 0, 4,  65'hFFFF_FFFF & 65'h0000_0010, "R2 plain truncates");
        run_fixed(2'b00, 32'hFFFF_FFFF, 0, 32, 65'd0, "R2 plain count W");
        run_fixed(2'b00, 32'hFFFF_FFFF, 0, 31, 65'h8000_0000, "R2 plain count W-1");
        for (int c = 0; c < 256; c += 7) run_model(2'b00, 32'h1234_5679, 0, c, "R2 plain sweep");
    endtask

    task automatic t_trap;
        run_fixed(2'b01, 32'h0000_0005, 0, 3,  65'h28, "R3 trap clean");
        run_fixed(2'b01, 32'hC000_0000, 0, 1,  65'h8000_0000, "R3 trap negative fits");
        run_fixed(2'b01, 32'h4000_0000, 0, 1,  {1'b1, 64'd0}, "R4 trap sign flip");
        run_fixed(2'b01, 32'h0000_0001, 0, 31, {1'b1, 64'd0}, "R4 trap into sign");
        run_fixed(2'b01, 32'h0000_0000, 0, 32, {1'b1, 64'd0}, "R5 trap zero overshift");
        run_fixed(2'b01, 32'h0000_0001, 0, 200, {1'b1, 64'd0}, "R5 trap large count");
        for (int c = 0; c < 40; c++) run_model(2'b01, 32'hFFFF_8000, 0, c, "R4 trap sweep");
    endtask

    task automatic t_sat;
        run_fixed(2'b10, 32'hFFFF_FFFD, 0, 2,  65'hFFFF_FFF4, "R6 sat negative fits");
        run_fixed(2'b10, 32'h4000_0000, 0, 1,  65'h7FFF_FFFF, "R7 sat positive clamp");
        run_fixed(2'b10, 32'h8000_0001, 0, 1,  65'h8000_0000, "R7 sat negative clamp");
        run_fixed(2'b10, 32'hFFFF_FFFF, 0, 40, 65'h8000_0000, "R7 sat overshift negative");
        run_fixed(2'b10, 32'h0000_0000, 0, 255, 65'd0, "R7 sat zero operand");
        for (int c = 0; c < 40; c++) run_model(2'b10, 32'h0000_1234, 0, c, "R7 sat sweep");
    endtask

    task automatic t_wide;
        run_fixed(2'b11, 32'hFFFF_FFFF, 0, 32, 65'hFFFF_FFFF_0000_0000, "R8 wide count W");
        run_fixed(2'b11, 32'hFFFF_FFFF, 0, 63, 65'h8000_0000_0000_0000, "R8 wide count 2W-1");
        run_fixed(2'b11, 32'hFFFF_FFFF, 0, 64, 65'd0, "R9 wide count 2W");
        for (int c = 0; c < 256; c += 5) run_model(2'b11, 32'h8765_4321, 0, c, "R9 wide sweep");
    endtask

    task automatic t_poison;
        for (int op = 0; op < 4; op++)
            run_fixed(2'(op), 32'h0000_0001, 1, 1, {1'b1, 64'd0}, "R10 poison input");
    endtask

    task automatic t_nomod;
        logic [64:0] g0, gw;
        apply(2'b00, 32'h0000_00A5, 0, 0, g0);
        apply(2'b00, 32'h0000_00A5, 0, 32, gw);
        check(g0 != gw && gw == 0, "R11 count W vs 0", gw, 65'd0);
        run_fixed(2'b00, 32'h0000_00A5, 0, 33, 65'd0, "R11 count W+1");
        run_fixed(2'b01, 32'h0000_00A5, 0, 36, {1'b1, 64'd0}, "R11 trap W+4");
    endtask

    task automatic t_upper;
        logic [64:0] g;
        apply(2'b10, 32'h7000_0000, 0, 3, g);
        check(g[63:32] == 0, "R12 sat upper zero", g, {33'd0, g[31:0]});
        apply(2'b00, 32'hFFFF_FFFF, 0, 16, g);
        check(g[63:32] == 0, "R12 plain upper zero", g, {33'd0, g[31:0]});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_idle();
        t_plain();
        t_trap();
        t_sat();
        t_wide();
        t_poison();
        t_nomod();
        t_upper();
        t_idle();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule